// File: doc/BRIEF.md
# Three-Wire Serial Control Register File

This block is the configuration port of a stereo audio converter. A host shifts 16-bit command words in over three wires: a data line, a bit clock and a latch line. Each line is synchronized into the system clock domain, and the block detects its rising edges. A small receive state machine counts the incoming bits. When the latch rises after exactly sixteen bits, the word is committed. Three address bits inside the word choose which program register takes the payload.

The program registers drive the converter's control outputs. These cover per-channel attenuation bytes with their load bits, mute, de-emphasis, operation enable, input word width, serial format, frame polarity, attenuator mode, filter roll-off, output phase, output clock choice, sample rate and zero detection. A fifth register holds the differential output mode and the clock-loss detector disable. It stays locked until an unlock key has been written into spare bits of the control register. While the hardware mode input is high, every serial write is dropped.

Receive states: `ST_IDLE` (no bits since the last latch), `ST_SHIFT` (1 to 15 bits), `ST_FULL` (exactly 16 bits) and `ST_OVER` (more than 16 bits). The transitions are as follows:
- A bit-clock edge moves `ST_IDLE` to `ST_SHIFT`.
- The sixteenth bit moves `ST_SHIFT` to `ST_FULL`.
- A further bit moves `ST_FULL` to `ST_OVER`.
- A latch edge returns any state to `ST_IDLE`. Only the exit from `ST_FULL` commits the word.

Top module: `tw_ctrl_port`

## Requirements
- R1: Each bit is captured on a rising edge of `sclk` from the level on `sdata`. The first bit received ends up in word bit 15 and the last in bit 0.
- R2: A rising edge of `slatch` commits the word only when exactly 16 bits have arrived since the previous latch edge. With 15 or 17 bits the word is dropped. Every latch edge restarts the bit count.
- R3: Word bits 11:9 select the target register, and bits 15:12 have no effect.
- R4: Address 000 loads `att_left` from bits 7:0 and `load_left` from bit 8. Address 001 loads `att_right` and `load_right` from the same bit positions.
- R5: Address 010 sets `mute` from bit 0, `deemph` from bit 1, `op_en` from bit 2 and `word_width` from bits 4:3.
- R6: Address 011 sets the following outputs:
  - `fmt_sel` from bit 0
  - `lr_pol` from bit 1
  - `att_ctl` from bit 2
  - `slow_rolloff` from bit 3
  - `phase_rev` from bit 4
  - `clko_sel` from bit 5
  - `rate_sel` from bits 7:6
  - `zero_det` from bit 8
- R7: Address 110 sets `diff_mode` from bits 5:4 and `clkloss_dis` from bit 6, but only while unlocked. Writing 1111 to bits 8:5 at address 010 unlocks the register. Any other value there locks it. Reset also locks it.
- R8: Writes to addresses 100, 101 and 111 change no output.
- R9: While `hw_lock` is high, committed words change no output.
- R10: After reset, `att_left` and `att_right` are 0xFF and every other control output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_lock | input | 1 | Hardware mode active; blocks serial writes |
| sdata | input | 1 | Serial data |
| sclk | input | 1 | Serial bit clock |
| slatch | input | 1 | Serial latch |
| att_left | output | 8 | Left attenuation byte |
| load_left | output | 1 | Left attenuation load bit |
| att_right | output | 8 | Right attenuation byte |
| load_right | output | 1 | Right attenuation load bit |
| mute | output | 1 | Soft mute |
| deemph | output | 1 | De-emphasis enable |
| op_en | output | 1 | Converter operation enable |
| word_width | output | 2 | Input word width code |
| fmt_sel | output | 1 | Serial audio format select |
| lr_pol | output | 1 | Frame clock polarity |
| att_ctl | output | 1 | Attenuator mode |
| slow_rolloff | output | 1 | Slow filter roll-off |
| phase_rev | output | 1 | Output phase reverse |
| clko_sel | output | 1 | Output clock rate select |
| rate_sel | output | 2 | Sample rate select |
| zero_det | output | 1 | Infinite-zero detect enable |
| diff_mode | output | 2 | Differential output mode |
| clkloss_dis | output | 1 | Clock-loss detector disable |

## Verification
The bench builds the block with its defaults: a 16-bit word, three-bit address at bit 9 and two synchronizer stages. With these values every receive state can be reached with short frames, including the 15-bit and 17-bit cases that must be dropped. The full address space fits in a dozen table rows, so the locked and unlocked paths to the hidden register can each be exercised several times. The serial lines are held for four system clocks per phase, well above the synchronizer depth, so edge detection is exercised at its intended margin.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } rx_state_e;

    localparam int ADDR_LSB = 9;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_LEFT   = 3'b000;
    localparam logic [ADDR_W-1:0] A_RIGHT  = 3'b001;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'b010;
    localparam logic [ADDR_W-1:0] A_FMT    = 3'b011;
    localparam logic [ADDR_W-1:0] A_HIDDEN = 3'b110;

    localparam logic [3:0] UNLOCK_KEY = 4'hF;
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/tw_word_fsm.sv
module tw_word_fsm
    import tw_ctrl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic              latch_rise,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);
    localparam int CW = $clog2(WORD_W + 1);

    rx_state_e       state, nxt;
    logic [CW-1:0]   cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (latch_rise)    nxt = ST_IDLE;
                      else if (bit_rise) nxt = (WORD_W == 1) ? ST_FULL : ST_SHIFT;
            ST_SHIFT: if (latch_rise)    nxt = ST_IDLE;
                      else if (bit_rise && cnt == CW'(WORD_W - 1)) nxt = ST_FULL;
            ST_FULL:  if (latch_rise)    nxt = ST_IDLE;
                      else if (bit_rise) nxt = ST_OVER;
            ST_OVER:  if (latch_rise)    nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    // bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            word_o <= '0;
        end else if (latch_rise) begin
            cnt <= '0;
        end else if (bit_rise) begin
            word_o <= {word_o[WORD_W-2:0], bit_val};
            if (state == ST_IDLE || state == ST_SHIFT) cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        commit_o = latch_rise && (state == ST_FULL);
    end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
    import tw_ctrl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ATT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              blocked,
    input  logic [WORD_W-1:0] word,
    output logic [ATT_W:0]    left_q,
    output logic [ATT_W:0]    right_q,
    output logic [4:0]        ctrl_q,
    output logic [8:0]        fmt_q,
    output logic [2:0]        hid_q
);
    logic              unlocked;
    logic [ADDR_W-1:0] addr;

    assign addr = word[ADDR_LSB +: ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q   <= {1'b0, {ATT_W{1'b1}}};
            right_q  <= {1'b0, {ATT_W{1'b1}}};
            ctrl_q   <= '0;
            fmt_q    <= '0;
            hid_q    <= '0;
            unlocked <= 1'b0;
        end else if (commit && !blocked) begin
            case (addr)
                A_LEFT:   left_q  <= word[ATT_W:0];
                A_RIGHT:  right_q <= word[ATT_W:0];
                A_CTRL: begin
                    ctrl_q   <= word[4:0];
                    unlocked <= (word[8:5] == UNLOCK_KEY);
                end
                A_FMT:    fmt_q   <= word[8:0];
                A_HIDDEN: if (unlocked) hid_q <= word[6:4];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tw_ctrl_port.sv
module tw_ctrl_port
    import tw_ctrl_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ATT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_lock,
    input  logic             sdata,
    input  logic             sclk,
    input  logic             slatch,
    output logic [ATT_W-1:0] att_left,
    output logic             load_left,
    output logic [ATT_W-1:0] att_right,
    output logic             load_right,
    output logic             mute,
    output logic             deemph,
    output logic             op_en,
    output logic [1:0]       word_width,
    output logic             fmt_sel,
    output logic             lr_pol,
    output logic             att_ctl,
    output logic             slow_rolloff,
    output logic             phase_rev,
    output logic             clko_sel,
    output logic [1:0]       rate_sel,
    output logic             zero_det,
    output logic [1:0]       diff_mode,
    output logic             clkloss_dis
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw_in, lvl, rise;
    logic [WORD_W-1:0] word_w;
    logic              commit_w;
    logic [ATT_W:0]    left_q, right_q;
    logic [4:0]        ctrl_q;
    logic [8:0]        fmt_q;
    logic [2:0]        hid_q;

    assign raw_in = {slatch, sclk, sdata};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .level (lvl[g]),
            .rise  (rise[g])
        );
    end

    tw_word_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (rise[1]),
        .bit_val    (lvl[0]),
        .latch_rise (rise[2]),
        .word_o     (word_w),
        .commit_o   (commit_w)
    );

    tw_reg_bank #(.WORD_W(WORD_W), .ATT_W(ATT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit_w),
        .blocked (hw_lock),
        .word    (word_w),
        .left_q  (left_q),
        .right_q (right_q),
        .ctrl_q  (ctrl_q),
        .fmt_q   (fmt_q),
        .hid_q   (hid_q)
    );

    assign {load_left, att_left}   = left_q;
    assign {load_right, att_right} = right_q;
    assign {word_width, op_en, deemph, mute} = ctrl_q;
    assign {zero_det, rate_sel, clko_sel, phase_rev,
            slow_rolloff, att_ctl, lr_pol, fmt_sel} = fmt_q;
    assign {clkloss_dis, diff_mode} = hid_q;
endmodule

// File: rtl/tw_ctrl_port_chk.sv
module tw_ctrl_port_chk #(
    parameter int WORD_W = 16,
    parameter int ATT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_lock,
    input logic              commit,
    input logic [WORD_W-1:0] word,
    input logic [ATT_W:0]    left_v,
    input logic [2:0]        hid_v,
    input logic [2*ATT_W+19:0] all_v,
    input logic [2*ATT_W+19:0] dflt_v
);
    // R2: a word reaches the registers only through a commit
    a_r2_no_change_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(all_v));

    // R2: a commit is a single-cycle event
    a_r2_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R9: hardware mode freezes every output
    a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |=> $stable(all_v));

    // R7: hidden fields move only on a commit to address 110
    a_r7_hidden_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && word[11:9] == 3'b110) |=> $stable(hid_v));

    // R4: left fields move only on a commit to address 000
    a_r4_left_only_addr0: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && word[11:9] == 3'b000) |=> $stable(left_v));

    // R10: defaults visible on the first cycle out of reset
    a_r10_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_v == dflt_v));
endmodule

bind tw_ctrl_port tw_ctrl_port_chk #(.WORD_W(WORD_W), .ATT_W(ATT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_lock (hw_lock),
    .commit  (commit_w),
    .word    (word_w),
    .left_v  (left_q),
    .hid_v   (hid_q),
    .all_v   ({left_q, right_q, ctrl_q, fmt_q, hid_q}),
    .dflt_v  ({1'b0, {ATT_W{1'b1}}, 1'b0, {ATT_W{1'b1}}, 17'd0})
);

// File: tb/tw_ctrl_port_test.sv
`timescale 1ns/1ps
module tw_ctrl_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_lock = 1'b0, sdata = 1'b0, sclk = 1'b0, slatch = 1'b0;
    logic [7:0] att_left, att_right;
    logic load_left, load_right, mute, deemph, op_en, fmt_sel, lr_pol, att_ctl;
    logic slow_rolloff, phase_rev, clko_sel, zero_det, clkloss_dis;
    logic [1:0] word_width, rate_sel, diff_mode;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    tw_ctrl_port uut (
        .clk(clk), .rst_n(rst_n), .hw_lock(hw_lock), .sdata(sdata), .sclk(sclk),
        .slatch(slatch), .att_left(att_left), .load_left(load_left),
        .att_right(att_right), .load_right(load_right), .mute(mute),
        .deemph(deemph), .op_en(op_en), .word_width(word_width),
        .fmt_sel(fmt_sel), .lr_pol(lr_pol), .att_ctl(att_ctl),
        .slow_rolloff(slow_rolloff), .phase_rev(phase_rev), .clko_sel(clko_sel),
        .rate_sel(rate_sel), .zero_det(zero_det), .diff_mode(diff_mode),
        .clkloss_dis(clkloss_dis)
    );

    // groups: left{ld,att} right{ld,att} ctrl{ww,op,de,mu} fmt{zd,rate,clko,rev,slow,atc,lrp,fmt} hid{cdd,diff}
    logic [34:0] obs;
    assign obs = {load_left, att_left, load_right, att_right,
                  word_width, op_en, deemph, mute,
                  zero_det, rate_sel, clko_sel, phase_rev, slow_rolloff, att_ctl, lr_pol, fmt_sel,
                  clkloss_dis, diff_mode};

    localparam logic [34:0] DEFAULTS = {9'h0FF, 9'h0FF, 5'h00, 9'h000, 3'h0};

    // {requirement, command word, expected left, right, ctrl, fmt, hidden}
    localparam int NV = 12;
    localparam logic [54:0] VEC [NV] = '{
        {4'd4,  16'h0012, 9'h012, 9'h0FF, 5'h00, 9'h000, 3'h0}, // R4 left
        {4'd4,  16'h0334, 9'h012, 9'h134, 5'h00, 9'h000, 3'h0}, // R4 right
        {4'd3,  16'hF1AB, 9'h1AB, 9'h134, 5'h00, 9'h000, 3'h0}, // R3 upper nibble ignored
        {4'd7,  16'h0C70, 9'h1AB, 9'h134, 5'h00, 9'h000, 3'h0}, // R7 locked write dropped
        {4'd5,  16'h05F5, 9'h1AB, 9'h134, 5'h15, 9'h000, 3'h0}, // R5 ctrl + unlock key
        {4'd7,  16'h0C70, 9'h1AB, 9'h134, 5'h15, 9'h000, 3'h7}, // R7 hidden write accepted
        {4'd5,  16'h040A, 9'h1AB, 9'h134, 5'h0A, 9'h000, 3'h7}, // R5 ctrl, relock
        {4'd7,  16'h0C20, 9'h1AB, 9'h134, 5'h0A, 9'h000, 3'h7}, // R7 relocked write dropped
        {4'd6,  16'h0769, 9'h1AB, 9'h134, 5'h0A, 9'h169, 3'h7}, // R6 format fields
        {4'd8,  16'h08FF, 9'h1AB, 9'h134, 5'h0A, 9'h169, 3'h7}, // R8 address 100
        {4'd8,  16'h0EFF, 9'h1AB, 9'h134, 5'h0A, 9'h169, 3'h7}, // R8 address 111
        {4'd6,  16'h0696, 9'h1AB, 9'h134, 5'h0A, 9'h096, 3'h7}  // R6 other pattern, R1 bit order
    };

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input int req, input logic [34:0] got, input logic [34:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // shifts nbits, most significant first; bits above 15 are sent as 0
    task automatic send(input logic [15:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdata = (i < 16) ? w[i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        slatch = 1'b1;
        wait_clk(4);
        slatch = 1'b0;
        wait_clk(6);
        @(negedge clk);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        check(10, obs, DEFAULTS); // R10 reset state

        // R1..R8 table walk
        for (int k = 0; k < NV; k++) begin
            send(VEC[k][50:35], 16);
            check(int'(VEC[k][54:51]), obs, VEC[k][34:0]);
        end

        // R2: 15-bit frame dropped
        send(16'h0000, 15);
        check(2, obs, {9'h1AB, 9'h134, 5'h0A, 9'h096, 3'h7});
        // R2: 17-bit frame dropped
        send(16'h0000, 17);
        check(2, obs, {9'h1AB, 9'h134, 5'h0A, 9'h096, 3'h7});
        // R2: count restarted by the latch, so a proper frame now lands
        send(16'h0055, 16);
        check(2, obs, {9'h055, 9'h134, 5'h0A, 9'h096, 3'h7});

        // R9: hardware mode blocks writes
        hw_lock = 1'b1;
        send(16'h03FF, 16);
        check(9, obs, {9'h055, 9'h134, 5'h0A, 9'h096, 3'h7});
        send(16'h05E0, 16);
        check(9, obs, {9'h055, 9'h134, 5'h0A, 9'h096, 3'h7});
        hw_lock = 1'b0;
        // R9: writes resume afterwards
        send(16'h03FF, 16);
        check(9, obs, {9'h055, 9'h1FF, 5'h0A, 9'h096, 3'h7});

        // R10: reset in mid-operation
        wait_clk(1);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        check(10, obs, DEFAULTS);

        // R7: reset relocks the hidden register
        send(16'h0C70, 16);
        check(7, obs, DEFAULTS);
        // R7: unlock key with zero payload, then hidden write
        send(16'h05E0, 16);
        send(16'h0C50, 16);
        check(7, obs, {9'h0FF, 9'h0FF, 5'h00, 9'h000, 3'h5});

        summary();
    end
endmodule